// File: doc/BRIEF.md
# Sampled Adaptive Block Size Selector

This block picks the best fetch granularity for a cache level by watching the live access stream. Four shadow tag directories run side by side. Each models a small sampled cache of 8 sets by 8 ways with true LRU. They use line sizes of 64, 128, 256 and 512 bytes. Every access is scored in each directory: a hit earns one point, and a miss costs a penalty that grows with that directory's block size. At the end of each epoch the best-scoring size is published as a 2-bit code. All scores are then halved, so older behaviour fades out.

The selected size drives a large-block prefetch path. When a demand miss arrives and the path is enabled, the block issues a single request. The request names a 512-byte region and carries a mask of the 64-byte lines that make up the aligned block of the selected size. Lines already touched in the most recently tracked region are removed from the mask. A separate window counts demand misses. When that count reaches a limit scaled by the block size, the path is switched off for the next window.

The block is fed with cache-line addresses (byte address without its 6 offset bits) and a demand-miss flag from the real cache. It holds no data.

Top module: `blksz_selector`

## Requirements
- R1: Directory k (k = 0..3, block of 64·2^k bytes) takes its set index from line address bits [k+2:k] and its tag from all line address bits above k+2; it holds 8 sets of 8 ways.
- R2: A hit makes the hit way most recently used; a miss writes the tag into the least recently used way of the set and makes it most recently used; invalid ways are filled before any valid way is evicted.
- R3: Each directory keeps one signed score of SCORE_W bits; a hit adds 1, a miss subtracts 2^k, and the result saturates at the signed range limits.
- R4: On the access that completes each EPOCH accesses, blk_sel becomes the code k of the highest updated score (0=64, 1=128, 2=256, 3=512 bytes); on a tie the smaller code wins; blk_sel changes at no other time.
- R5: On that same access, after the comparison, every score is replaced by its arithmetic right shift by one.
- R6: On the access that completes each WIN accesses, the demand misses in the window (that access included) are compared with (MISS_NUM·WIN/64) >> blk_sel, using blk_sel from before the update; lb_enable becomes 0 if the count reaches the limit and 1 otherwise, and the count restarts.
- R7: A valid access with acc_miss=1 while lb_enable=1 produces, one cycle later, pf_valid=1, pf_region = line address bits above 2, and pf_mask bit j set for each line j (line address bits [2:0]) inside the block of the current size that holds the access.
- R8: A single tracker remembers one 512-byte region and the lines accessed or prefetched in it; the accessing line and tracked lines of the same region are cleared from pf_mask; pf_valid stays 0 when the mask would be empty, on hits, and on idle cycles; an access to a new region restarts the tracker.
- R9: During and after reset, blk_sel=0, lb_enable=1 and pf_valid=0 until accesses change them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_line | input | ADDR_W-6 | Cache-line address of the access |
| acc_miss | input | 1 | The access missed in the real cache |
| blk_sel | output | 2 | Selected block size code (64 << code bytes) |
| lb_enable | output | 1 | Large-block prefetch path enabled |
| pf_valid | output | 1 | Prefetch request valid |
| pf_region | output | ADDR_W-9 | 512-byte region of the request |
| pf_mask | output | 8 | Lines of the region to fetch |

## Verification
If a directory holds a wrong LRU order or tag, it hits or misses where it should not. Its score then drifts, and the fault shows up only at the next epoch boundary, as a wrong blk_sel code. After that it also shows in the width of pf_mask. A bad miss window shows up at the next window boundary as a wrong lb_enable. A tracker fault shows up at once, on the next miss to the same region, as a mask that is too wide or too narrow. For these reasons the reference model is compared on every cycle over long runs that cross many epochs and windows, including runs that drive the scores into saturation.

// File: rtl/blksz_pkg.sv
package blksz_pkg;
  localparam int NUM_SIZES    = 4;
  localparam int REGION_LINES = 8;
  typedef logic [1:0] size_code_t;

  // Lines of the aligned block of size 2^code lines holding line li of a region
  function automatic logic [REGION_LINES-1:0] span_mask(input logic [2:0] li,
                                                        input size_code_t code);
    logic [REGION_LINES-1:0] m;
    logic [3:0] width;
    logic [3:0] start;
    width = 4'd1 << code;
    start = {1'b0, li} & ~(width - 4'd1);
    for (int j = 0; j < REGION_LINES; j++) begin
      m[j] = (4'(j) >= start) && (4'(j) < start + width);
    end
    return m;
  endfunction
endpackage

// File: rtl/blksz_monitor.sv
module blksz_monitor #(
  parameter int LINE_W  = 26,
  parameter int SIZE_SH = 0,
  parameter int SETS    = 8,
  parameter int WAYS    = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      acc_valid,
  input  logic [LINE_W-SIZE_SH-1:0] blk_addr,
  output logic                      hit
);
  localparam int SET_W = $clog2(SETS);
  localparam int WAY_W = $clog2(WAYS);
  localparam int TAG_W = LINE_W - SIZE_SH - SET_W;

  logic [WAYS-1:0][TAG_W-1:0] tag_q  [SETS];
  logic [WAYS-1:0]            vld_q  [SETS];
  logic [WAYS-1:0][WAY_W-1:0] rank_q [SETS];

  logic [SET_W-1:0]           set_idx;
  logic [TAG_W-1:0]           tag_in;
  logic [WAYS-1:0][TAG_W-1:0] tag_row, tag_d;
  logic [WAYS-1:0]            vld_row, vld_d, hit_vec;
  logic [WAYS-1:0][WAY_W-1:0] rank_row, rank_d;
  logic [WAY_W-1:0]           tgt, old_rank;

  assign set_idx = blk_addr[SET_W-1:0];
  assign tag_in  = blk_addr[LINE_W-SIZE_SH-1 -: TAG_W];

  always_comb begin
    tag_row  = tag_q[set_idx];
    vld_row  = vld_q[set_idx];
    rank_row = rank_q[set_idx];
    for (int w = 0; w < WAYS; w++) begin
      hit_vec[w] = vld_row[w] && (tag_row[w] == tag_in);
    end
    hit = |hit_vec;
    // target: the hit way, else the way ranked least recent
    tgt = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (hit ? hit_vec[w] : (rank_row[w] == WAY_W'(WAYS - 1))) begin
        tgt = WAY_W'(w);
      end
    end
    old_rank = rank_row[tgt];
    for (int w = 0; w < WAYS; w++) begin
      tag_d[w]  = tag_row[w];
      vld_d[w]  = vld_row[w];
      rank_d[w] = rank_row[w];
      if (WAY_W'(w) == tgt) begin
        tag_d[w]  = tag_in;
        vld_d[w]  = 1'b1;
        rank_d[w] = '0;
      end else if (rank_row[w] < old_rank) begin
        rank_d[w] = rank_row[w] + WAY_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        vld_q[s] <= '0;
        for (int w = 0; w < WAYS; w++) begin
          tag_q[s][w]  <= '0;
          rank_q[s][w] <= WAY_W'(w);
        end
      end
    end else if (acc_valid) begin
      tag_q[set_idx]  <= tag_d;
      vld_q[set_idx]  <= vld_d;
      rank_q[set_idx] <= rank_d;
    end
  end
endmodule

// File: rtl/blksz_arbiter.sv
module blksz_arbiter
  import blksz_pkg::*;
#(
  parameter int SCORE_W = 16,
  parameter int EPOCH   = 8192
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 acc_valid,
  input  logic [NUM_SIZES-1:0] hit,
  output size_code_t           blk_sel
);
  localparam int EPOCH_W = $clog2(EPOCH);
  localparam int WIDE    = SCORE_W + 4;
  localparam logic signed [WIDE-1:0] ONE  = WIDE'(1);
  localparam logic signed [WIDE-1:0] SMAX = WIDE'((64'sd1 <<< (SCORE_W - 1)) - 1);
  localparam logic signed [WIDE-1:0] SMIN = WIDE'(-(64'sd1 <<< (SCORE_W - 1)));

  logic signed [SCORE_W-1:0] score_q [NUM_SIZES];
  logic signed [SCORE_W-1:0] score_d [NUM_SIZES];
  logic signed [SCORE_W-1:0] sat    [NUM_SIZES];
  logic [EPOCH_W-1:0]        cnt_q, cnt_d;
  size_code_t                sel_q, sel_d, best_code;
  logic signed [SCORE_W-1:0] best;
  logic                      epoch_end;

  assign epoch_end = acc_valid && (cnt_q == EPOCH_W'(EPOCH - 1));

  always_comb begin
    for (int i = 0; i < NUM_SIZES; i++) begin
      logic signed [WIDE-1:0] sum;
      logic signed [WIDE-1:0] delta;
      delta = hit[i] ? ONE : -(ONE <<< i);
      sum   = WIDE'(score_q[i]) + delta;
      if (!acc_valid)     sat[i] = score_q[i];
      else if (sum > SMAX) sat[i] = SMAX[SCORE_W-1:0];
      else if (sum < SMIN) sat[i] = SMIN[SCORE_W-1:0];
      else                 sat[i] = sum[SCORE_W-1:0];
    end
    best      = sat[0];
    best_code = '0;
    for (int i = 1; i < NUM_SIZES; i++) begin
      if (sat[i] > best) begin
        best      = sat[i];
        best_code = size_code_t'(i);
      end
    end
    for (int i = 0; i < NUM_SIZES; i++) begin
      score_d[i] = epoch_end ? (sat[i] >>> 1) : sat[i];
    end
    sel_d = epoch_end ? best_code : sel_q;
    cnt_d = cnt_q;
    if (acc_valid) cnt_d = epoch_end ? '0 : cnt_q + EPOCH_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_SIZES; i++) score_q[i] <= '0;
      cnt_q <= '0;
      sel_q <= '0;
    end else if (acc_valid) begin
      for (int i = 0; i < NUM_SIZES; i++) score_q[i] <= score_d[i];
      cnt_q <= cnt_d;
      sel_q <= sel_d;
    end
  end

  assign blk_sel = sel_q;
endmodule

// File: rtl/blksz_lbpf.sv
module blksz_lbpf
  import blksz_pkg::*;
#(
  parameter int LINE_W   = 26,
  parameter int WIN      = 1024,
  parameter int MISS_NUM = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    acc_valid,
  input  logic [LINE_W-1:0]       acc_line,
  input  logic                    acc_miss,
  input  size_code_t              blk_sel,
  output logic                    lb_enable,
  output logic                    pf_valid,
  output logic [LINE_W-4:0]       pf_region,
  output logic [REGION_LINES-1:0] pf_mask
);
  localparam int REG_W    = LINE_W - 3;
  localparam int WCNT_W   = $clog2(WIN);
  localparam int MCNT_W   = $clog2(WIN + 1);
  localparam int LIM_BASE = MISS_NUM * WIN / 64;

  logic [WCNT_W-1:0]       win_q, win_d;
  logic [MCNT_W-1:0]       miss_q, miss_d, miss_inc;
  logic                    lb_q, lb_d;
  logic                    trk_vld_q;
  logic [REG_W-1:0]        trk_reg_q;
  logic [REGION_LINES-1:0] trk_mask_q, trk_mask_d, touched, issue;
  logic                    pfv_q, pfv_d;
  logic [REG_W-1:0]        pfr_q;
  logic [REGION_LINES-1:0] pfm_q;
  logic [REG_W-1:0]        region;
  logic [2:0]              li;
  logic                    win_end;
  int unsigned             lim;

  assign region   = acc_line[LINE_W-1:3];
  assign li       = acc_line[2:0];
  assign win_end  = acc_valid && (win_q == WCNT_W'(WIN - 1));
  assign miss_inc = miss_q + MCNT_W'(acc_miss);

  always_comb begin
    touched = (trk_vld_q && trk_reg_q == region) ? trk_mask_q : '0;
    touched[li] = 1'b1;
    issue = '0;
    if (acc_valid && acc_miss && lb_q) issue = span_mask(li, blk_sel) & ~touched;
    trk_mask_d = touched | issue;
    pfv_d      = |issue;
    lim        = 32'(LIM_BASE) >> blk_sel;
    lb_d       = lb_q;
    win_d      = win_q;
    miss_d     = miss_q;
    if (acc_valid) begin
      win_d  = win_end ? '0 : win_q + WCNT_W'(1);
      miss_d = win_end ? '0 : miss_inc;
      if (win_end) lb_d = !(32'(miss_inc) >= lim);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q      <= '0;
      miss_q     <= '0;
      lb_q       <= 1'b1;
      trk_vld_q  <= 1'b0;
      trk_reg_q  <= '0;
      trk_mask_q <= '0;
    end else if (acc_valid) begin
      win_q      <= win_d;
      miss_q     <= miss_d;
      lb_q       <= lb_d;
      trk_vld_q  <= 1'b1;
      trk_reg_q  <= region;
      trk_mask_q <= trk_mask_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pfv_q <= 1'b0;
      pfr_q <= '0;
      pfm_q <= '0;
    end else begin
      pfv_q <= pfv_d;
      if (pfv_d) begin
        pfr_q <= region;
        pfm_q <= issue;
      end
    end
  end

  assign lb_enable = lb_q;
  assign pf_valid  = pfv_q;
  assign pf_region = pfr_q;
  assign pf_mask   = pfm_q;
endmodule

// File: rtl/blksz_selector.sv
module blksz_selector
  import blksz_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int SETS     = 8,
  parameter int WAYS     = 8,
  parameter int SCORE_W  = 16,
  parameter int EPOCH    = 8192,
  parameter int WIN      = 1024,
  parameter int MISS_NUM = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic [ADDR_W-7:0] acc_line,
  input  logic              acc_miss,
  output logic [1:0]        blk_sel,
  output logic              lb_enable,
  output logic              pf_valid,
  output logic [ADDR_W-10:0] pf_region,
  output logic [7:0]        pf_mask
);
  localparam int LINE_W = ADDR_W - 6;

  logic [NUM_SIZES-1:0] hit;
  size_code_t           sel;

  for (genvar g = 0; g < NUM_SIZES; g++) begin : g_dir
    blksz_monitor #(
      .LINE_W (LINE_W),
      .SIZE_SH(g),
      .SETS   (SETS),
      .WAYS   (WAYS)
    ) u_dir (
      .clk      (clk),
      .rst_n    (rst_n),
      .acc_valid(acc_valid),
      .blk_addr (acc_line[LINE_W-1:g]),
      .hit      (hit[g])
    );
  end

  blksz_arbiter #(
    .SCORE_W(SCORE_W),
    .EPOCH  (EPOCH)
  ) u_arb (
    .clk      (clk),
    .rst_n    (rst_n),
    .acc_valid(acc_valid),
    .hit      (hit),
    .blk_sel  (sel)
  );

  blksz_lbpf #(
    .LINE_W  (LINE_W),
    .WIN     (WIN),
    .MISS_NUM(MISS_NUM)
  ) u_lbpf (
    .clk      (clk),
    .rst_n    (rst_n),
    .acc_valid(acc_valid),
    .acc_line (acc_line),
    .acc_miss (acc_miss),
    .blk_sel  (sel),
    .lb_enable(lb_enable),
    .pf_valid (pf_valid),
    .pf_region(pf_region),
    .pf_mask  (pf_mask)
  );

  assign blk_sel = sel;
endmodule

// File: rtl/blksz_checker.sv
module blksz_checker #(
  parameter int ADDR_W = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               acc_valid,
  input logic [ADDR_W-7:0]  acc_line,
  input logic               acc_miss,
  input logic [1:0]         blk_sel,
  input logic               lb_enable,
  input logic               pf_valid,
  input logic [ADDR_W-10:0] pf_region,
  input logic [7:0]         pf_mask
);
  // R7: a request only follows an enabled demand miss
  assert_pf_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid |-> $past(acc_valid && acc_miss && lb_enable));

  // R7: the request names the region of the access that caused it
  assert_pf_region_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid |-> pf_region == $past(acc_line[ADDR_W-7:3]));

  // R7: never more lines than the selected block holds
  assert_pf_width_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid |-> $countones(pf_mask) <= (32'd1 << $past(blk_sel)));

  // R8: the missing line itself is never requested, and no empty request
  assert_pf_skip_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid |-> (pf_mask != 8'd0) && !pf_mask[$past(acc_line[2:0])]);

  // R4: selection only moves on an access
  assert_sel_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(acc_valid) |-> $stable(blk_sel));

  // R6: gate only moves on an access
  assert_gate_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(acc_valid) |-> $stable(lb_enable));
endmodule

bind blksz_selector blksz_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .acc_valid(acc_valid),
  .acc_line (acc_line),
  .acc_miss (acc_miss),
  .blk_sel  (blk_sel),
  .lb_enable(lb_enable),
  .pf_valid (pf_valid),
  .pf_region(pf_region),
  .pf_mask  (pf_mask)
);

// File: tb/tb_blksz_selector.sv
module tb_blksz_selector;
  localparam int ADDR_W   = 32;
  localparam int SW       = 6;
  localparam int EPOCH    = 64;
  localparam int WIN      = 16;
  localparam int MISS_NUM = 32;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              acc_valid;
  logic [ADDR_W-7:0] acc_line;
  logic              acc_miss;
  logic [1:0]        blk_sel;
  logic              lb_enable;
  logic              pf_valid;
  logic [ADDR_W-10:0] pf_region;
  logic [7:0]        pf_mask;

  always #10 clk = ~clk;

  blksz_selector #(
    .ADDR_W(ADDR_W), .SCORE_W(SW), .EPOCH(EPOCH), .WIN(WIN), .MISS_NUM(MISS_NUM)
  ) dut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_line(acc_line),
    .acc_miss(acc_miss), .blk_sel(blk_sel), .lb_enable(lb_enable),
    .pf_valid(pf_valid), .pf_region(pf_region), .pf_mask(pf_mask)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // reference model state
  int unsigned dirq [4][8][$];
  int          sc [4];
  int          ep_cnt, win_cnt, win_miss, m_sel;
  bit          m_lb;
  bit          trk_v;
  int unsigned trk_reg;
  int unsigned trk_mask;
  bit          e_pfv;
  int unsigned e_reg, e_mask;
  int unsigned seed = 32'h1234_5678;

  task automatic chk(input bit ok, input string req, input int unsigned act,
                     input int unsigned exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int unsigned rnd();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed >> 8;
  endfunction

  task automatic model_reset();
    for (int k = 0; k < 4; k++) begin
      sc[k] = 0;
      for (int s = 0; s < 8; s++) dirq[k][s].delete();
    end
    ep_cnt = 0; win_cnt = 0; win_miss = 0; m_sel = 0; m_lb = 1'b1;
    trk_v = 1'b0; trk_reg = 0; trk_mask = 0; e_pfv = 1'b0; e_reg = 0; e_mask = 0;
  endtask

  task automatic model_access(input int unsigned line, input bit miss);
    int unsigned region, li, touched, issue, width, start, lim;
    int best, bsel;
    // directories and scores (R1 R2 R3)
    for (int k = 0; k < 4; k++) begin
      int unsigned st, tg;
      int pos;
      st  = (line >> k) & 7;
      tg  = line >> (k + 3);
      pos = -1;
      foreach (dirq[k][st][q]) if (pos < 0 && dirq[k][st][q] == tg) pos = q;
      if (pos >= 0) begin
        dirq[k][st].delete(pos);
        sc[k] += 1;
      end else begin
        if (dirq[k][st].size() == 8) void'(dirq[k][st].pop_back());
        sc[k] -= (1 << k);
      end
      dirq[k][st].push_front(tg);
      if (sc[k] > (1 << (SW - 1)) - 1) sc[k] = (1 << (SW - 1)) - 1;
      if (sc[k] < -(1 << (SW - 1)))    sc[k] = -(1 << (SW - 1));
    end
    // prefetch with the current gate and size (R7 R8)
    region  = line >> 3;
    li      = line & 7;
    touched = (trk_v && trk_reg == region) ? trk_mask : 0;
    touched |= (1 << li);
    issue = 0;
    if (miss && m_lb) begin
      width = 1 << m_sel;
      start = li & ~(width - 1);
      for (int j = 0; j < 8; j++) if (j >= start && j < start + width) issue |= (1 << j);
      issue &= ~touched;
    end
    e_pfv = (issue != 0);
    if (e_pfv) begin
      e_reg  = region;
      e_mask = issue;
    end
    trk_v = 1'b1; trk_reg = region; trk_mask = touched | issue;
    // miss window (R6) with size before any epoch update
    win_miss += miss;
    win_cnt++;
    if (win_cnt == WIN) begin
      lim  = (MISS_NUM * WIN / 64) >> m_sel;
      m_lb = !(win_miss >= lim);
      win_cnt = 0; win_miss = 0;
    end
    // epoch (R4 R5)
    ep_cnt++;
    if (ep_cnt == EPOCH) begin
      best = sc[0]; bsel = 0;
      for (int k = 1; k < 4; k++) if (sc[k] > best) begin best = sc[k]; bsel = k; end
      m_sel = bsel;
      for (int k = 0; k < 4; k++) sc[k] = sc[k] >>> 1;
      ep_cnt = 0;
    end
  endtask

  task automatic compare(input string tag);
    chk(blk_sel == 2'(m_sel), {"R1 R2 R3 R4 R5 blk_sel ", tag}, blk_sel, m_sel);
    chk(lb_enable == m_lb, {"R6 lb_enable ", tag}, lb_enable, m_lb);
    chk(pf_valid == e_pfv, {"R7 R8 pf_valid ", tag}, pf_valid, e_pfv);
    if (e_pfv && pf_valid) begin
      chk(pf_region == (ADDR_W-9)'(e_reg), {"R7 pf_region ", tag}, pf_region, e_reg);
      chk(pf_mask == 8'(e_mask), {"R7 R8 pf_mask ", tag}, pf_mask, e_mask);
    end
  endtask

  // called at a negative edge
  task automatic step(input bit v, input int unsigned line, input bit miss, input string tag);
    acc_valid = v;
    acc_line  = (ADDR_W-6)'(line);
    acc_miss  = miss;
    @(posedge clk);
    if (v) model_access(line, miss);
    else   e_pfv = 1'b0;
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    rst_n = 1'b0; acc_valid = 1'b0; acc_line = '0; acc_miss = 1'b0;
    model_reset();
    repeat (3) @(negedge clk);
    // R9: reset values
    chk(blk_sel == 2'd0, "R9 blk_sel in reset", blk_sel, 0);
    chk(lb_enable == 1'b1, "R9 lb_enable in reset", lb_enable, 1);
    chk(pf_valid == 1'b0, "R9 pf_valid in reset", pf_valid, 0);
    rst_n = 1'b1;
    step(1'b0, 0, 1'b0, "R9 after release");

    // R3: eight lines, eight touches each; all scores hit the cap, tie keeps code 0
    for (int i = 0; i < 64; i++) step(1'b1, 32'h400 + i / 8, (i % 8) == 0, "R3 saturation");
    chk(blk_sel == 2'd0, "R3 R4 tie after saturation", blk_sel, 0);

    // R4: two touches per line in a stream favour the large block
    for (int i = 0; i < 256; i++) step(1'b1, 32'h1000 + i / 2, (i % 2) == 0, "R4 stream");

    // R2 R5: random reuse over a small footprint
    for (int i = 0; i < 512; i++) begin
      int unsigned r;
      r = rnd();
      step(1'b1, 32'h2000 + (r % 48) * 3, r[20], "R2 R5 reuse");
    end

    // R6: page-strided misses trip the gate
    for (int i = 0; i < 128; i++) step(1'b1, 32'h3000 + i * 64, 1'b1, "R6 strided");

    // R6 R8: sparse misses re-enable; idle gaps between accesses
    for (int i = 0; i < 384; i++) begin
      int unsigned r;
      r = rnd();
      step(r[3], 32'h5000 + (r % 40), r[9] & r[10], "R8 mixed");
    end

    // R7 R8: repeated misses in one region shrink the mask
    for (int i = 0; i < 200; i++) begin
      int unsigned r;
      r = rnd();
      step(1'b1, 32'h6000 + (i / 8) * 8 + (r % 8), 1'b1, "R7 R8 region");
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule